// File: doc/BRIEF.md
# Docking-window positive decode with retry and skip-once

This block sits on the primary side of a docking bridge. It watches the start of every bus transaction and compares the address and command against a set of programmable windows. A matching cycle is claimed by positive decode and answered with a target retry, because the remote ISA bus behind the dock cannot complete it within the primary bus's timing. The retried cycle's address and command are remembered. The remote side later reports whether that cycle really belongs to the dock. If it does not, the next retry of the same cycle is left alone, so the host's subtractive decoder can take it.

Each window can be marked as an ISA window. Another host agent may also claim known local ISA devices by positive decode. To avoid a clash with it, an enable input moves the claim on ISA windows one clock later. In that mode the block claims only if no other agent has driven DEVSEL# by then. Non-ISA windows always claim at the medium point.

Top module: `dock_window_claim`

## Requirements
- R1: After reset, DEVSEL#, STOP# and TRDY# outputs are high (deasserted) and the output drive enable `ctl_oe_o` is low.
- R2: A cycle start is the first clock edge at which FRAME# is sampled low after being high. That cycle hits when at least one enabled window matches it. A window matches when the address bits selected by its mask equal its base, and when the command fits its space. The space bit = 1 accepts commands 4'h2 and 4'h3 (I/O), and space bit = 0 accepts 4'h6 and 4'h7 (memory). A cycle that hits no window is never claimed.
- R3: A claim on a non-ISA window, or on any window while slow mode is off, drives DEVSEL# and STOP# low, TRDY# high and `ctl_oe_o` high. These values appear after the second clock edge following the cycle-start edge.
- R4: Once claimed, STOP# and DEVSEL# stay low until the first edge at which FRAME# is sampled high. After that edge they return high and `ctl_oe_o` stays high for one more cycle, then drops.
- R5: With slow mode on, a cycle that hits an ISA window (the lowest-numbered matching window decides) is claimed one edge later than R3. That is after the third edge following cycle start, provided DEVSEL# input was high at the first, second and third edges.
- R6: With slow mode on, an ISA-window cycle is not claimed at all if the DEVSEL# input is sampled low at any of those three edges.
- R7: Slow mode has no effect on cycles that hit a non-ISA window. They keep the R3 timing, and their DEVSEL# input is not examined.
- R8: A verdict pulse (`verdict_valid_i` = 1, `verdict_dest_i` = 0 meaning not destined) arms a skip for the most recently claimed address and command. The next cycle start with exactly that address and command is not claimed, and the skip is then used up. A cycle with the same address but a different command is claimed.
- R9: A verdict with `verdict_dest_i` = 1 disarms the skip, so the same cycle is retried again. Claiming any other cycle replaces the remembered cycle and also disarms the skip.
- R10: A verdict that arrives before any cycle has been claimed since reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n_i | input | 1 | FRAME# as seen on the primary bus |
| ad_i | input | AW | Address/data bus, address valid at cycle start |
| cbe_i | input | 4 | Command/byte enables, command valid at cycle start |
| devsel_n_i | input | 1 | DEVSEL# driven by other agents |
| slow_en_i | input | 1 | 1 = move ISA-window claims to the slow point |
| win_en_i | input | NWIN | Per-window enable |
| win_io_i | input | NWIN | Per-window space: 1 = I/O, 0 = memory |
| win_isa_i | input | NWIN | Per-window ISA marking |
| win_base_i | input | NWIN*AW | Concatenated window bases, window 0 in the low bits |
| win_mask_i | input | NWIN*AW | Concatenated compare masks, 1 = bit compared |
| verdict_valid_i | input | 1 | One-cycle pulse carrying the remote verdict |
| verdict_dest_i | input | 1 | 1 = destined for the dock, 0 = not destined |
| devsel_n_o | output | 1 | DEVSEL# drive value |
| stop_n_o | output | 1 | STOP# drive value |
| trdy_n_o | output | 1 | TRDY# drive value |
| ctl_oe_o | output | 1 | Drive enable for the three target control lines |

## Verification
I/O and memory cycles are sent inside and outside each window, with the wrong command space, and to a disabled window. Together these separate a correct masked compare from one that ignores the space bit or the enable. With slow mode on, the same ISA window is tried with no other claimer, with a fast competitor and with a medium one. Non-ISA traffic is interleaved, which shows whether the deferral and the DEVSEL# watch are confined to ISA windows. Verdict sequences cover several cases: not-destined followed by one and then two repeats, destined, a different cycle between the verdict and the repeat, a command-only difference, and a verdict right after reset. These show whether the skip fires exactly once, on exactly the right cycle.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RETRY,
      ST_TURN
   } claim_st_e;

   localparam logic [3:0] CMD_IO_RD  = 4'h2;
   localparam logic [3:0] CMD_IO_WR  = 4'h3;
   localparam logic [3:0] CMD_MEM_RD = 4'h6;
   localparam logic [3:0] CMD_MEM_WR = 4'h7;

   // Command accepted by a window of the given space (1 = I/O, 0 = memory)
   function automatic logic cmd_fits(input logic [3:0] cmd, input logic io_space);
      if (io_space) return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
      return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
   endfunction

endpackage

// File: rtl/dwc_window_match.sv
module dwc_window_match #(
   parameter int AW   = 32,
   parameter int NWIN = 4
) (
   input  logic [AW-1:0]      addr_i,
   input  logic [3:0]         cmd_i,
   input  logic [NWIN-1:0]    win_en_i,
   input  logic [NWIN-1:0]    win_io_i,
   input  logic [NWIN-1:0]    win_isa_i,
   input  logic [NWIN*AW-1:0] win_base_i,
   input  logic [NWIN*AW-1:0] win_mask_i,
   output logic               hit_o,
   output logic               isa_o
);
   import dwc_pkg::*;

   logic [NWIN-1:0] hit_vec;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic [AW-1:0] base_w;
      logic [AW-1:0] mask_w;
      assign base_w     = win_base_i[w*AW +: AW];
      assign mask_w     = win_mask_i[w*AW +: AW];
      assign hit_vec[w] = win_en_i[w] && cmd_fits(cmd_i, win_io_i[w])
                          && (((addr_i ^ base_w) & mask_w) == '0);
   end

   // Lowest-numbered matching window decides the ISA marking
   always_comb begin
      hit_o = |hit_vec;
      isa_o = 1'b0;
      for (int w = NWIN - 1; w >= 0; w--) begin
         if (hit_vec[w]) isa_o = win_isa_i[w];
      end
   end

endmodule

// File: rtl/dwc_retry_memory.sv
module dwc_retry_memory #(
   parameter int AW        = 32,
   parameter bit MATCH_CMD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture_i,
   input  logic [AW-1:0] cap_addr_i,
   input  logic [3:0]    cap_cmd_i,
   input  logic [AW-1:0] probe_addr_i,
   input  logic [3:0]    probe_cmd_i,
   input  logic          take_skip_i,
   input  logic          verdict_valid_i,
   input  logic          verdict_dest_i,
   output logic          skip_o
);
   logic [AW-1:0] lat_addr_q;
   logic [3:0]    lat_cmd_q;
   logic          lat_valid_q;
   logic          armed_q;
   logic          cmd_same;

   if (MATCH_CMD) begin : g_full_cmd
      assign cmd_same = (probe_cmd_i == lat_cmd_q);
   end else begin : g_space_only
      // Read and write of one space count as the same cycle
      assign cmd_same = (probe_cmd_i[3:1] == lat_cmd_q[3:1]);
   end

   assign skip_o = armed_q && lat_valid_q && cmd_same && (probe_addr_i == lat_addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_addr_q  <= '0;
         lat_cmd_q   <= '0;
         lat_valid_q <= 1'b0;
         armed_q     <= 1'b0;
      end else if (capture_i) begin
         lat_addr_q  <= cap_addr_i;
         lat_cmd_q   <= cap_cmd_i;
         lat_valid_q <= 1'b1;
         armed_q     <= 1'b0;
      end else if (take_skip_i) begin
         armed_q     <= 1'b0;
      end else if (verdict_valid_i && lat_valid_q) begin
         armed_q     <= !verdict_dest_i;
      end
   end

endmodule

// File: rtl/dwc_claim_fsm.sv
module dwc_claim_fsm #(
   parameter int MED_EDGE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic slow_i,
   input  logic frame_n_i,
   input  logic devsel_n_i,
   output logic devsel_n_o,
   output logic stop_n_o,
   output logic oe_o,
   output logic capture_o,
   output logic idle_o
);
   import dwc_pkg::*;

   localparam int SLOW_EDGE = MED_EDGE + 1;
   localparam int CNT_W     = $clog2(SLOW_EDGE + 1);

   claim_st_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             slow_q;
   logic             seen_q;
   logic             seen_nxt;
   logic             med_due;
   logic             slow_due;
   logic             go_claim;
   logic             give_up;

   always_comb begin
      cnt_nxt  = cnt_q + 1'b1;
      seen_nxt = seen_q | ~devsel_n_i;
      med_due  = !slow_q && (cnt_nxt == CNT_W'(MED_EDGE));
      slow_due = slow_q && (cnt_nxt == CNT_W'(SLOW_EDGE));
      go_claim = (st_q == ST_WAIT) && (med_due || (slow_due && !seen_nxt));
      give_up  = (st_q == ST_WAIT) && slow_due && seen_nxt;
   end

   assign capture_o = go_claim;
   assign idle_o    = (st_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         slow_q     <= 1'b0;
         seen_q     <= 1'b0;
         devsel_n_o <= 1'b1;
         stop_n_o   <= 1'b1;
         oe_o       <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_WAIT;
                  cnt_q  <= '0;
                  seen_q <= 1'b0;
                  slow_q <= slow_i;
               end
            end
            ST_WAIT: begin
               cnt_q  <= cnt_nxt;
               seen_q <= seen_nxt;
               if (go_claim) begin
                  st_q       <= ST_RETRY;
                  devsel_n_o <= 1'b0;
                  stop_n_o   <= 1'b0;
                  oe_o       <= 1'b1;
               end else if (give_up) begin
                  st_q <= ST_IDLE;
               end
            end
            ST_RETRY: begin
               if (frame_n_i) begin
                  st_q       <= ST_TURN;
                  devsel_n_o <= 1'b1;
                  stop_n_o   <= 1'b1;
               end
            end
            ST_TURN: begin
               st_q <= ST_IDLE;
               oe_o <= 1'b0;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dock_window_claim.sv
module dock_window_claim #(
   parameter int AW        = 32,
   parameter int NWIN      = 4,
   parameter int MED_EDGE  = 2,
   parameter bit MATCH_CMD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_n_i,
   input  logic [AW-1:0]      ad_i,
   input  logic [3:0]         cbe_i,
   input  logic               devsel_n_i,
   input  logic               slow_en_i,
   input  logic [NWIN-1:0]    win_en_i,
   input  logic [NWIN-1:0]    win_io_i,
   input  logic [NWIN-1:0]    win_isa_i,
   input  logic [NWIN*AW-1:0] win_base_i,
   input  logic [NWIN*AW-1:0] win_mask_i,
   input  logic               verdict_valid_i,
   input  logic               verdict_dest_i,
   output logic               devsel_n_o,
   output logic               stop_n_o,
   output logic               trdy_n_o,
   output logic               ctl_oe_o
);
   if (AW < 4) begin : g_bad_aw
      $error("dock_window_claim: AW must be at least 4");
   end
   if (NWIN < 1) begin : g_bad_nwin
      $error("dock_window_claim: NWIN must be at least 1");
   end
   if (MED_EDGE < 1) begin : g_bad_med
      $error("dock_window_claim: MED_EDGE must be at least 1");
   end

   logic          frame_q;
   logic          fsm_idle;
   logic          start_edge;
   logic          win_hit;
   logic          win_isa;
   logic          skip;
   logic          claim_start;
   logic          take_skip;
   logic          capture;
   logic [AW-1:0] cur_addr_q;
   logic [3:0]    cur_cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) frame_q <= 1'b1;
      else        frame_q <= frame_n_i;
   end

   assign start_edge  = fsm_idle && frame_q && !frame_n_i;
   assign claim_start = start_edge && win_hit && !skip;
   assign take_skip   = start_edge && win_hit && skip;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr_q <= '0;
         cur_cmd_q  <= '0;
      end else if (claim_start) begin
         cur_addr_q <= ad_i;
         cur_cmd_q  <= cbe_i;
      end
   end

   dwc_window_match #(.AW(AW), .NWIN(NWIN)) u_match (
      .addr_i     (ad_i),
      .cmd_i      (cbe_i),
      .win_en_i   (win_en_i),
      .win_io_i   (win_io_i),
      .win_isa_i  (win_isa_i),
      .win_base_i (win_base_i),
      .win_mask_i (win_mask_i),
      .hit_o      (win_hit),
      .isa_o      (win_isa)
   );

   dwc_retry_memory #(.AW(AW), .MATCH_CMD(MATCH_CMD)) u_mem (
      .clk             (clk),
      .rst_n           (rst_n),
      .capture_i       (capture),
      .cap_addr_i      (cur_addr_q),
      .cap_cmd_i       (cur_cmd_q),
      .probe_addr_i    (ad_i),
      .probe_cmd_i     (cbe_i),
      .take_skip_i     (take_skip),
      .verdict_valid_i (verdict_valid_i),
      .verdict_dest_i  (verdict_dest_i),
      .skip_o          (skip)
   );

   dwc_claim_fsm #(.MED_EDGE(MED_EDGE)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (claim_start),
      .slow_i     (slow_en_i && win_isa),
      .frame_n_i  (frame_n_i),
      .devsel_n_i (devsel_n_i),
      .devsel_n_o (devsel_n_o),
      .stop_n_o   (stop_n_o),
      .oe_o       (ctl_oe_o),
      .capture_o  (capture),
      .idle_o     (fsm_idle)
   );

   // Retry only: data is never accepted
   assign trdy_n_o = 1'b1;

endmodule

// File: rtl/dwc_checker.sv
module dwc_checker (
   input logic clk,
   input logic rst_n,
   input logic frame_n_i,
   input logic devsel_n_o,
   input logic stop_n_o,
   input logic trdy_n_o,
   input logic ctl_oe_o
);
   // R3: retry shape, STOP# only together with DEVSEL# and TRDY# high
   a_r3_retry_shape: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n_o |-> (!devsel_n_o && trdy_n_o && ctl_oe_o));

   // R4: retry held while FRAME# stays low
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n_o && !frame_n_i) |=> !stop_n_o);

   // R4: released after FRAME# seen high, drive kept one more cycle
   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n_o && frame_n_i) |=> (stop_n_o && devsel_n_o && ctl_oe_o));

   // R4: drive enable drops one cycle after release
   a_r4_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_oe_o && stop_n_o) |=> !ctl_oe_o);

   // R1: nothing asserted while not driving
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_oe_o |-> (devsel_n_o && stop_n_o && trdy_n_o));

endmodule

bind dock_window_claim dwc_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_n_i  (frame_n_i),
   .devsel_n_o (devsel_n_o),
   .stop_n_o   (stop_n_o),
   .trdy_n_o   (trdy_n_o),
   .ctl_oe_o   (ctl_oe_o)
);

// File: tb/dock_window_claim_tb_top.sv
`timescale 1ns/100ps
module dock_window_claim_tb_top;
   localparam int AW = 32;
   localparam int NW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           frame_n = 1'b1;
   logic [AW-1:0]  ad = '0;
   logic [3:0]     cbe = '0;
   logic           dev_in = 1'b1;
   logic           slow_en = 1'b0;
   logic [NW-1:0]  w_en, w_io, w_isa;
   logic [NW*AW-1:0] w_base, w_mask;
   logic           v_valid = 1'b0;
   logic           v_dest = 1'b0;
   logic           devsel_n_o, stop_n_o, trdy_n_o, ctl_oe_o;

   int n_checks = 0;
   int n_bad    = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   // window 0: I/O 0x300/16 ISA; 1: mem 0xA0000/128K non-ISA;
   // 2: disabled I/O 0x5000; 3: mem 0xC00000/1M ISA
   assign w_en  = 4'b1011;
   assign w_io  = 4'b0101;
   assign w_isa = 4'b1001;
   assign w_base = {32'h00C0_0000, 32'h0000_5000, 32'h000A_0000, 32'h0000_0300};
   assign w_mask = {32'hFFF0_0000, 32'hFFFF_FF00, 32'hFFFE_0000, 32'hFFFF_FFF0};

   dock_window_claim dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .ad_i(ad), .cbe_i(cbe),
      .devsel_n_i(dev_in), .slow_en_i(slow_en), .win_en_i(w_en), .win_io_i(w_io),
      .win_isa_i(w_isa), .win_base_i(w_base), .win_mask_i(w_mask),
      .verdict_valid_i(v_valid), .verdict_dest_i(v_dest),
      .devsel_n_o(devsel_n_o), .stop_n_o(stop_n_o), .trdy_n_o(trdy_n_o),
      .ctl_oe_o(ctl_oe_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   function automatic bit ref_hit(input logic [31:0] a, input logic [3:0] c, output bit isa);
      isa = 1'b0;
      for (int w = 0; w < NW; w++) begin
         bit sp;
         sp = w_io[w] ? (c == 4'h2 || c == 4'h3) : (c == 4'h6 || c == 4'h7);
         if (w_en[w] && sp && (((a ^ w_base[w*32 +: 32]) & w_mask[w*32 +: 32]) == 0)) begin
            isa = w_isa[w];
            return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   int          m_phase, m_cnt;
   bit          m_slow, m_seen, m_fq, m_latv, m_arm;
   logic [31:0] m_cura, m_lata;
   logic [3:0]  m_curc, m_latc;
   bit          e_dev, e_stop, e_oe;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_fq = 1; m_latv = 0; m_arm = 0;
         e_dev = 1; e_stop = 1; e_oe = 0;
      end else begin
         bit used, isa, h;
         used = 0;
         case (m_phase)
            0: if (m_fq && !frame_n) begin
                  h = ref_hit(ad, cbe, isa);
                  if (h) begin
                     if (m_arm && m_latv && ad == m_lata && cbe == m_latc) begin
                        m_arm = 0; used = 1;
                     end else begin
                        m_phase = 1; m_cnt = 0; m_seen = 0;
                        m_slow = slow_en && isa; m_cura = ad; m_curc = cbe;
                     end
                  end
               end
            1: begin
                  m_cnt++;
                  if (!dev_in) m_seen = 1;
                  if ((!m_slow && m_cnt == 2) || (m_slow && m_cnt == 3 && !m_seen)) begin
                     m_phase = 2; e_dev = 0; e_stop = 0; e_oe = 1;
                     m_lata = m_cura; m_latc = m_curc; m_latv = 1; m_arm = 0; used = 1;
                  end else if (m_slow && m_cnt == 3) m_phase = 0;
               end
            2: if (frame_n) begin m_phase = 3; e_dev = 1; e_stop = 1; end
            default: begin m_phase = 0; e_oe = 0; end
         endcase
         if (!used && v_valid && m_latv) m_arm = !v_dest;
         m_fq = frame_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(devsel_n_o == e_dev, cur_req, devsel_n_o, e_dev);
         chk(stop_n_o == e_stop, cur_req, stop_n_o, e_stop);
         chk(trdy_n_o == 1'b1, cur_req, trdy_n_o, 1);
         chk(ctl_oe_o == e_oe, cur_req, ctl_oe_o, e_oe);
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_cycle(input logic [31:0] a, input logic [3:0] c, input int other_at,
                           output int lat, output int nstop, output int noe);
      lat = -1; nstop = 0; noe = 0;
      @(negedge clk);
      frame_n = 1'b0; ad = a; cbe = c;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (!devsel_n_o && lat < 0) lat = i;
         if (!stop_n_o) nstop++;
         if (ctl_oe_o) noe++;
         if (i == other_at) dev_in = 1'b0;
         if (i == 6) begin frame_n = 1'b1; dev_in = 1'b1; end
      end
   endtask

   task automatic verdict(input bit dest);
      @(negedge clk); v_valid = 1'b1; v_dest = dest;
      @(negedge clk); v_valid = 1'b0;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      int l, s, o;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(devsel_n_o && stop_n_o && trdy_n_o && !ctl_oe_o, "R1", ctl_oe_o, 0);

      cur_req = "R3";
      do_cycle(32'h0000_0305, 4'h2, -1, l, s, o);
      chk(l == 3, "R3", l, 3);
      chk(s == 4, "R4", s, 4);
      chk(o == 5, "R4", o, 5);

      cur_req = "R8";
      verdict(1'b0);
      do_cycle(32'h0000_0305, 4'h2, -1, l, s, o);
      chk(l == -1, "R8", l, -1);
      do_cycle(32'h0000_0305, 4'h2, -1, l, s, o);
      chk(l == 3, "R8", l, 3);

      cur_req = "R2";
      do_cycle(32'h000A_1234, 4'h6, -1, l, s, o);
      chk(l == 3, "R2", l, 3);
      do_cycle(32'h0000_0310, 4'h2, -1, l, s, o);
      chk(l == -1, "R2", l, -1);
      do_cycle(32'h0000_0300, 4'h6, -1, l, s, o);
      chk(l == -1, "R2", l, -1);
      do_cycle(32'h0000_5010, 4'h3, -1, l, s, o);
      chk(l == -1 && o == 0, "R2", o, 0);
      do_cycle(32'h0000_0300, 4'h3, -1, l, s, o);
      chk(l == 3, "R2", l, 3);

      slow_en = 1'b1;
      cur_req = "R5";
      do_cycle(32'h0000_0302, 4'h2, -1, l, s, o);
      chk(l == 4, "R5", l, 4);
      chk(s == 3 && o == 4, "R5", s, 3);
      cur_req = "R7";
      do_cycle(32'h000A_0000, 4'h7, 2, l, s, o);
      chk(l == 3, "R7", l, 3);
      cur_req = "R6";
      do_cycle(32'h00C0_0010, 4'h6, 1, l, s, o);
      chk(l == -1, "R6", l, -1);
      do_cycle(32'h00C0_0010, 4'h6, 2, l, s, o);
      chk(l == -1 && o == 0, "R6", l, -1);
      cur_req = "R5";
      do_cycle(32'h00C0_0010, 4'h6, -1, l, s, o);
      chk(l == 4, "R5", l, 4);

      cur_req = "R9";
      verdict(1'b1);
      do_cycle(32'h00C0_0010, 4'h6, -1, l, s, o);
      chk(l == 4, "R9", l, 4);
      verdict(1'b0);
      do_cycle(32'h0000_0301, 4'h2, -1, l, s, o);
      chk(l == 4, "R9", l, 4);
      do_cycle(32'h00C0_0010, 4'h6, -1, l, s, o);
      chk(l == 4, "R9", l, 4);

      cur_req = "R8";
      verdict(1'b0);
      do_cycle(32'h00C0_0010, 4'h7, -1, l, s, o);
      chk(l == 4, "R8", l, 4);

      cur_req = "R10";
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      verdict(1'b0);
      do_cycle(32'h0000_0305, 4'h2, -1, l, s, o);
      chk(l == 4, "R10", l, 4);

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end
endmodule